// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the clocked front end of a flow-through synchronous burst SRAM. Its words are split into byte lanes of nine bits. On every rising clock edge it samples the address, the write data, two address strobes (one for a processor, one for a cache controller), three chip selects, a burst step input and the write controls. From these it classifies the edge as a new read, a new write, a burst continuation, a repeat of the current location, or a deselect. It also writes the selected lanes of a behavioural array, 256 words deep by default.

Read data is not registered on its way out. The array is addressed by the registered burst address, so a read's data appears on the bus in the same cycle that follows the sampling edge. A burst steps through the low two address bits in one of two orders: a wrapping increment or an XOR with a count. The order is chosen by a static, unregistered input. An asynchronous output enable gates the bus. The bus is also released during write and deselected cycles. The SRAM pin interface has no handshake: every clock edge accepts exactly one cycle and there is no back-pressure.

Top module: `sbs_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after it until a new cycle starts, the block is deselected and `dq_o` is high impedance.
- R2: A strobe starts a new cycle only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0 at the edge. A strobe that sees `sel1_n`=0 with `sel2`=0 or `sel3_n`=1 deselects the block.
- R3: A processor strobe (`strb_cpu_n`=0) sampled with `sel1_n`=1 is ignored. An ongoing burst continues as if no strobe had been given, or the controller strobe is evaluated if it is low.
- R4: A controller strobe (`strb_mc_n`=0) sampled with `sel1_n`=1 deselects the block, unless a qualified processor strobe takes priority.
- R5: A cycle started by the processor strobe is always a read, whatever the write inputs are. It takes priority over a simultaneous controller strobe. The word at `addr` drives `dq_o` during the cycle after the sampling edge.
- R6: When `wr_all_n`=0 in a controller-started or continuation cycle, both lanes are written: lane 0 is bits 8:0 and lane 1 is bits 17:9.
- R7: When `wr_all_n`=1, lane i is written only if `wr_n`=0 and `lane_n[i]`=0. With `wr_n`=1 nothing is written and the cycle is a read.
- R8: With `order_xor`=0, each edge with no strobe and `step_n`=0 advances the low two address bits as (start + count) mod 4. The upper bits stay at the start address.
- R9: With `order_xor`=1, the low two bits are (start XOR count). The input is not registered, so changing it changes the address immediately.
- R10: An edge with no strobe and `step_n`=1 during an active cycle keeps the same address. The new cycle repeats that location as a read or a write.
- R11: `dq_o` is driven only during an active read cycle with `out_en_n`=0. It is high impedance during writes and deselects, and it follows `out_en_n` without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W (8) | Word address, sampled on a strobe |
| wdata | input | LANES*LANE_W (18) | Write data |
| dq_o | output | LANES*LANE_W (18) | Read data bus, tri-state |
| strb_cpu_n | input | 1 | Processor address strobe, active low |
| strb_mc_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst step, active low |
| sel1_n | input | 1 | Chip select 1, active low |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_n | input | 1 | Lane write enable, active low |
| lane_n | input | LANES (2) | Per-lane write select, active low |
| order_xor | input | 1 | Burst order: 0 wrapping increment, 1 XOR |
| out_en_n | input | 1 | Asynchronous output enable, active low |

## Verification
The bench steers bursts across the wrap of the low address bits in both orders. A generator that carried into the upper bits, or that ignored the order input, would read the wrong words. It sends each strobe with `sel1_n` high during a live burst: a design that treated both strobes alike would either cut the burst or keep it. It also tries writes under the processor strobe and under single-lane selects, where a wrong decode corrupts a neighbouring lane or a word that must stay intact. It toggles the output enable between edges, where a registered enable would lag by one cycle.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE = 3'd0,
    CYC_PROC = 3'd1,
    CYC_CTRL = 3'd2,
    CYC_OFF  = 3'd3,
    CYC_CONT = 3'd4
  } cyc_e;
endpackage

// File: rtl/sbs_cycle_decode.sv
module sbs_cycle_decode
  import sbs_pkg::*;
(
  input  logic strb_cpu_n,
  input  logic strb_mc_n,
  input  logic sel1_n,
  input  logic sel2,
  input  logic sel3_n,
  input  logic active,
  output cyc_e kind
);
  logic chip_on;
  assign chip_on = !sel1_n && sel2 && !sel3_n;

  always_comb begin
    if (!strb_cpu_n && !sel1_n)   kind = chip_on ? CYC_PROC : CYC_OFF;
    else if (!strb_mc_n)          kind = chip_on ? CYC_CTRL : CYC_OFF;
    else if (active)              kind = CYC_CONT;
    else                          kind = CYC_IDLE;
  end
endmodule

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr #(
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          inc,
  input  logic          order_xor,
  input  logic [BB-1:0] load_lo,
  output logic [BB-1:0] cur_lo,
  output logic [BB-1:0] nxt_lo
);
  logic [BB-1:0] base_q, cnt_q, base_d, cnt_d;

  function automatic logic [BB-1:0] seq(input logic [BB-1:0] b, input logic [BB-1:0] c,
                                        input logic x);
    return x ? (b ^ c) : (b + c);
  endfunction

  assign base_d = load ? load_lo : base_q;
  assign cnt_d  = load ? '0 : (inc ? cnt_q + BB'(1) : cnt_q);
  assign cur_lo = seq(base_q, cnt_q, order_xor);
  assign nxt_lo = seq(base_d, cnt_d, order_xor);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  // R8: a linear step moves the low bits by one, modulo the burst length
  assert_linear_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && !order_xor) |=> (order_xor || cur_lo == $past(cur_lo) + BB'(1)));
endmodule

// File: rtl/sbs_lane_write.sv
module sbs_lane_write #(
  parameter int LANES = 2
) (
  input  logic             wr_all_n,
  input  logic             wr_n,
  input  logic [LANES-1:0] lane_n,
  output logic [LANES-1:0] lanes
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lanes[i] = !wr_all_n || (!wr_n && !lane_n[i]);
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_bank
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[i]) mem[waddr] <= wdata[i*LANE_W +: LANE_W];
    end
    assign rdata[i*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  parameter int BB     = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] dq_o,
  input  logic                    strb_cpu_n,
  input  logic                    strb_mc_n,
  input  logic                    step_n,
  input  logic                    sel1_n,
  input  logic                    sel2,
  input  logic                    sel3_n,
  input  logic                    wr_all_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_n,
  input  logic                    order_xor,
  input  logic                    out_en_n
);
  localparam int W    = LANES * LANE_W;
  localparam int HI_W = ADDR_W - BB;

  cyc_e              kind;
  logic              act_q, rd_q;
  logic [HI_W-1:0]   hi_q;
  logic [BB-1:0]     cur_lo, nxt_lo;
  logic [LANES-1:0]  lanes, we_lanes;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [W-1:0]      rdata;
  logic              load, inc, drive;

  sbs_cycle_decode u_dec (
    .strb_cpu_n(strb_cpu_n), .strb_mc_n(strb_mc_n), .sel1_n(sel1_n),
    .sel2(sel2), .sel3_n(sel3_n), .active(act_q), .kind(kind)
  );

  assign load = rst_n && (kind == CYC_PROC || kind == CYC_CTRL);
  assign inc  = rst_n && (kind == CYC_CONT) && !step_n;

  sbs_burst_addr #(.BB(BB)) u_burst (
    .clk(clk), .rst_n(rst_n), .load(load), .inc(inc), .order_xor(order_xor),
    .load_lo(addr[BB-1:0]), .cur_lo(cur_lo), .nxt_lo(nxt_lo)
  );

  sbs_lane_write #(.LANES(LANES)) u_lane (
    .wr_all_n(wr_all_n), .wr_n(wr_n), .lane_n(lane_n), .lanes(lanes)
  );

  assign we_lanes = (rst_n && (kind == CYC_CTRL || kind == CYC_CONT)) ? lanes : '0;
  assign waddr    = (kind == CYC_CTRL) ? addr : {hi_q, nxt_lo};
  assign raddr    = {hi_q, cur_lo};

  sbs_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_mem (
    .clk(clk), .we(we_lanes), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      rd_q  <= 1'b0;
      hi_q  <= '0;
    end else begin
      unique case (kind)
        CYC_PROC: begin act_q <= 1'b1; rd_q <= 1'b1;       hi_q <= addr[ADDR_W-1:BB]; end
        CYC_CTRL: begin act_q <= 1'b1; rd_q <= ~|lanes;    hi_q <= addr[ADDR_W-1:BB]; end
        CYC_CONT: begin rd_q <= ~|lanes; end
        CYC_OFF:  begin act_q <= 1'b0; end
        default:  ;
      endcase
    end
  end

  assign drive = act_q && rd_q && !out_en_n;
  assign dq_o  = drive ? rdata : {W{1'bz}};

  // R5: a qualified processor strobe always opens a read
  assert_proc_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_cpu_n && !sel1_n && sel2 && !sel3_n) |=> (act_q && rd_q));
  // R4: controller strobe with select 1 high deselects
  assert_ctrl_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_mc_n && sel1_n) |=> !act_q);
  // R3: processor strobe with select 1 high leaves a live burst running
  assert_cpu_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_cpu_n && sel1_n && strb_mc_n && act_q) |=> act_q);
  // R10: no strobe and no step keeps the address
  assert_hold_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_cpu_n && strb_mc_n && step_n && act_q && $stable(order_xor)) |=>
      (!$changed(order_xor) -> $stable(raddr)));
  // R6: global write enables every lane of an accepted write
  assert_all_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_all_n && (kind == CYC_CTRL || kind == CYC_CONT)) |-> (&we_lanes));
  // R11: the bus is released after a write edge
  assert_write_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|we_lanes) |=> !drive);
endmodule

// File: tb/sim_sbs_ctrl.sv
`timescale 1ns/1ps
module sim_sbs_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [17:0] wdata = '0;
  wire  [17:0] dq_o;
  logic strb_cpu_n = 1, strb_mc_n = 1, step_n = 1;
  logic sel1_n = 0, sel2 = 1, sel3_n = 0;
  logic wr_all_n = 1, wr_n = 1;
  logic [1:0] lane_n = 2'b11;
  logic order_xor = 0, out_en_n = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sbs_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .dq_o(dq_o),
    .strb_cpu_n(strb_cpu_n), .strb_mc_n(strb_mc_n), .step_n(step_n),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .wr_all_n(wr_all_n),
    .wr_n(wr_n), .lane_n(lane_n), .order_xor(order_xor), .out_en_n(out_en_n)
  );

  // behavioural reference
  logic [17:0] ref_mem [256];
  bit          m_act = 0, m_rd = 0;
  logic [7:0]  m_base = '0;
  int          m_cnt = 0;

  function automatic logic [7:0] m_addr(input logic [7:0] b, input int c);
    logic [1:0] lo;
    lo = order_xor ? (b[1:0] ^ 2'(c)) : 2'(b[1:0] + c);
    return {b[7:2], lo};
  endfunction

  task automatic model_edge();
    bit on;
    logic [1:0] ln;
    on = !sel1_n && sel2 && !sel3_n;
    ln[0] = !wr_all_n || (!wr_n && !lane_n[0]);
    ln[1] = !wr_all_n || (!wr_n && !lane_n[1]);
    if (!rst_n) begin m_act = 0; m_rd = 0; return; end
    if (!strb_cpu_n && !sel1_n) begin
      if (on) begin m_act = 1; m_rd = 1; m_base = addr; m_cnt = 0; end
      else m_act = 0;
    end else if (!strb_mc_n) begin
      if (on) begin
        m_act = 1; m_base = addr; m_cnt = 0; m_rd = (ln == 0);
        if (ln[0]) ref_mem[addr][8:0]  = wdata[8:0];
        if (ln[1]) ref_mem[addr][17:9] = wdata[17:9];
      end else m_act = 0;
    end else if (m_act) begin
      if (!step_n) m_cnt = (m_cnt + 1) % 4;
      m_rd = (ln == 0);
      if (ln[0]) ref_mem[m_addr(m_base, m_cnt)][8:0]  = wdata[8:0];
      if (ln[1]) ref_mem[m_addr(m_base, m_cnt)][17:9] = wdata[17:9];
    end
  endtask

  function automatic logic [17:0] expect_dq();
    if (m_act && m_rd && !out_en_n) return ref_mem[m_addr(m_base, m_cnt)];
    return 18'bz;
  endfunction

  task automatic compare(input string tag);
    logic [17:0] e;
    e = expect_dq();
    checks++;
    if (dq_o !== e) begin
      errors++;
      $display("FAIL %s dq_o actual=%h expected=%h at %0t", tag, dq_o, e, $time);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
    strb_cpu_n = 1; strb_mc_n = 1; step_n = 1;
    wr_all_n = 1; wr_n = 1; lane_n = 2'b11;
  endtask

  task automatic wr_start(input logic [7:0] a, input logic [17:0] d, input string tag);
    strb_mc_n = 0; addr = a; wdata = d; wr_all_n = 0;
    step(tag);
  endtask

  task automatic rd_start(input logic [7:0] a, input string tag);
    strb_cpu_n = 0; addr = a;
    step(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = 'x;
    @(negedge clk);
    step("R1"); step("R1");
    rst_n = 1;
    step("R1");                              // reset state: bus released

    // R6 global write then linear burst writes wrapping from 0x12
    wr_start(8'h12, 18'h1A012, "R6");
    wdata = 18'h2B013; wr_all_n = 0; step_n = 0; step("R8");
    wdata = 18'h3C010; wr_all_n = 0; step_n = 0; step("R8");
    wdata = 18'h0D011; wr_all_n = 0; step_n = 0; step("R8");

    // R5 read and R8 linear read burst with wrap
    rd_start(8'h12, "R5");
    for (int k = 0; k < 4; k++) begin step_n = 0; step("R8"); end
    // R9 interleaved from 0x13, and async switch of order
    order_xor = 1;
    rd_start(8'h13, "R9");
    for (int k = 0; k < 3; k++) begin step_n = 0; step("R9"); end
    order_xor = 0; #1 compare("R9");
    order_xor = 1; #1 compare("R9");
    order_xor = 0;

    // R7 byte writes
    wr_start(8'h20, 18'h3FFFF, "R6");
    strb_mc_n = 0; addr = 8'h20; wdata = 18'h00000; wr_n = 0; lane_n = 2'b10; step("R7");
    rd_start(8'h20, "R7");
    strb_mc_n = 0; addr = 8'h21; wdata = 18'h155AA; wr_all_n = 0; step("R6");
    wdata = 18'h0; wr_n = 0; lane_n = 2'b01; step("R7");   // hold: lane 1 of 0x21
    step("R10");
    strb_mc_n = 0; addr = 8'h21; wdata = 18'h3FFFF; wr_n = 1; lane_n = 2'b00; step("R7");
    step("R10"); step("R10");

    // R5 processor strobe ignores write inputs and beats controller strobe
    strb_cpu_n = 0; strb_mc_n = 0; addr = 8'h12; wdata = 18'h0; wr_all_n = 0; step("R5");
    rd_start(8'h12, "R5");

    // R3 processor strobe with select 1 high during a burst
    rd_start(8'h10, "R3");
    sel1_n = 1; strb_cpu_n = 0; step_n = 0; addr = 8'h20; step("R3");
    sel1_n = 1; strb_cpu_n = 0; step_n = 1; step("R3");
    sel1_n = 0;
    // R4 controller strobe with select 1 high
    sel1_n = 1; strb_mc_n = 0; step("R4");
    sel1_n = 0; step("R4"); step_n = 0; step("R4");

    // R2 qualified selects
    rd_start(8'h11, "R2");
    sel2 = 0; strb_mc_n = 0; step("R2");
    sel2 = 1; rd_start(8'h11, "R2");
    sel3_n = 1; strb_cpu_n = 0; step("R2");
    sel3_n = 0; rd_start(8'h11, "R2");
    sel3_n = 1; step_n = 0; step("R2");     // no strobe: burst continues
    sel3_n = 0;

    // R11 async output enable
    rd_start(8'h13, "R11");
    out_en_n = 1; #1 compare("R11");
    out_en_n = 0; #1 compare("R11");
    out_en_n = 1; step("R11");
    out_en_n = 0; #1 compare("R11");
    wr_all_n = 0; wdata = 18'h2468A; step("R11");   // write cycle: released
    step("R10");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule